// File: doc/BRIEF.md
# Wide-to-Narrow Synchronous Bus Bridge

This block joins a 64-bit fabric port, which offers independent read and write command channels, to a 32-bit peripheral bus that carries reads and writes over one shared command channel. Every accepted command, together with its write data and byte strobes, goes into a single command FIFO in the order it arrived. A sequencer drains that FIFO onto the narrow bus one command at a time. A full-width access is split into two 32-bit beats. For a full-width read, the two returned words are merged into one 64-bit response.

The narrow side may run at the fabric clock rate or at an integer fraction of it. This is modelled by a clock enable `nce`: the narrow-side state advances, and a beat or returned read word counts, only on clock edges where `nce` is high. A late request never overtakes an earlier one. Whatever its urgency, it waits behind everything already in the FIFO.

Top module: `wide_narrow_bridge`

## Requirements
- R1: After synchronous reset, `n_valid` and `rsp_valid` are low and both `wr_ready` and `rd_ready` are high.
- R2: A write with `wr_wide`=1 produces two narrow write beats. The first beat carries address bits [2:0]=000, `wr_data[31:0]` and `wr_strb[3:0]`. The second beat carries address bit 2 set, `wr_data[63:32]` and `wr_strb[7:4]`.
- R3: A write with `wr_wide`=0 produces one narrow beat at the unchanged address. Its data and strobes are taken from the upper lane when address bit 2 is 1 and from the lower lane otherwise.
- R4: A read with `rd_wide`=1 issues two narrow reads, first at address bits [2:0]=000 and then with bit 2 set. One `rsp_valid` pulse returns {second word, first word}.
- R5: A read with `rd_wide`=0 issues one narrow read at the unchanged address. The response places the word in the upper half when address bit 2 is 1 and in the lower half otherwise, with the other half zero.
- R6: Narrow beats and responses follow the exact order in which commands were accepted, across both wide channels.
- R7: When a write and a read are accepted in the same cycle, the write's beats go out before the read's.
- R8: `wr_ready` and `rd_ready` are low whenever fewer than two FIFO entries are free. With the narrow side stalled, exactly DEPTH-1 back-to-back writes are accepted.
- R9: While a narrow beat waits for `n_ready`, the beat is held with its address, data, strobes and direction unchanged. No new beat is offered while a read word is still outstanding.
- R10: A beat transfers, and a returned read word is taken, only on a clock edge with `nce` high.
- R11: `rsp_valid` is a one-cycle pulse, asserted in the cycle after the clock edge that takes the final read word of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| nce | input | 1 | Narrow-side clock enable |
| wr_valid | input | 1 | Write command valid |
| wr_ready | output | 1 | Write command accepted when high |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 64 | Write data |
| wr_strb | input | 8 | Write byte strobes |
| wr_wide | input | 1 | 1: 64-bit access, 0: 32 bits or less |
| rd_valid | input | 1 | Read command valid |
| rd_ready | output | 1 | Read command accepted when high |
| rd_addr | input | 32 | Read byte address |
| rd_wide | input | 1 | 1: 64-bit access, 0: 32 bits or less |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 64 | Read response data |
| n_valid | output | 1 | Narrow beat valid |
| n_ready | input | 1 | Narrow beat accepted |
| n_write | output | 1 | Narrow beat direction, 1 = write |
| n_addr | output | 32 | Narrow beat byte address |
| n_wdata | output | 32 | Narrow write data |
| n_strb | output | 4 | Narrow write strobes |
| n_rvalid | input | 1 | Narrow read word valid |
| n_rdata | input | 32 | Narrow read word |

## Verification
Every internal fault of this block surfaces on the narrow port within one or two beats. A beat index that slips puts the wrong lane or address bit 2 on the very next narrow transfer. A wrong FIFO pointer or count replays, skips or reorders a command, and the beat-by-beat comparison catches that at the first affected beat. A sequencer that ignores `nce` or the outstanding read shifts every later beat, and the response pulse then comes at the wrong cycle or carries the wrong word. A fill count that is off by one moves the ready drop by one accepted write.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int AW  = 32;
    localparam int NW  = 32;
    localparam int WW  = 2 * NW;
    localparam int NSB = NW / 8;
    localparam int WSB = WW / 8;

    typedef struct packed {
        logic           is_wr;
        logic           wide;
        logic [AW-1:0]  addr;
        logic [WW-1:0]  data;
        logic [WSB-1:0] strb;
    } cmd_t;

    // Address of a narrow beat: full-width accesses force bit 2 to the beat index.
    function automatic logic [AW-1:0] beat_addr(cmd_t c, logic beat);
        return c.wide ? {c.addr[AW-1:3], beat, 2'b00} : c.addr;
    endfunction

    function automatic logic [NW-1:0] lane_data(cmd_t c, logic upper);
        return upper ? c.data[WW-1:NW] : c.data[NW-1:0];
    endfunction

    function automatic logic [NSB-1:0] lane_strb(cmd_t c, logic upper);
        return upper ? c.strb[WSB-1:NSB] : c.strb[NSB-1:0];
    endfunction
endpackage

// File: rtl/bridge_cmd_fifo.sv
module bridge_cmd_fifo
    import bridge_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_a,
    input  cmd_t                       ent_a,
    input  logic                       push_b,
    input  cmd_t                       ent_b,
    input  logic                       pop,
    output cmd_t                       head,
    output logic [$clog2(DEPTH):0]     fill
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    cmd_t          mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW-1:0] b_slot;

    // Port A always takes the earlier slot when both push together.
    assign b_slot = push_a ? wptr + PW'(1) : wptr;
    assign head   = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_a) mem[wptr]   <= ent_a;
        if (push_b) mem[b_slot] <= ent_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            wptr <= wptr + PW'(push_a) + PW'(push_b);
            rptr <= rptr + PW'(pop);
            fill <= fill + CW'(push_a) + CW'(push_b) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (CW'(push_a) + CW'(push_b)) <= (CW'(DEPTH) - fill)) else $error("fifo overflow"); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fill != '0)) else $error("fifo underflow"); // R6
endmodule

// File: rtl/bridge_narrow_seq.sv
module bridge_narrow_seq
    import bridge_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           nce,
    input  cmd_t           head,
    input  logic           have,
    output logic           pop,
    output logic           n_valid,
    input  logic           n_ready,
    output logic           n_write,
    output logic [AW-1:0]  n_addr,
    output logic [NW-1:0]  n_wdata,
    output logic [NSB-1:0] n_strb,
    input  logic           n_rvalid,
    input  logic [NW-1:0]  n_rdata,
    output logic           rsp_valid,
    output logic [WW-1:0]  rsp_data
);
    logic          beat;
    logic          wait_rd;
    logic [NW-1:0] lo_buf;
    logic          lane, last, issue, take;

    assign lane    = head.wide ? beat : head.addr[2];
    assign last    = !head.wide || beat;
    assign n_valid = have && !wait_rd;
    assign n_write = head.is_wr;
    assign n_addr  = beat_addr(head, beat);
    assign n_wdata = lane_data(head, lane);
    assign n_strb  = lane_strb(head, lane);
    assign issue   = nce && n_valid && n_ready;
    assign take    = nce && wait_rd && n_rvalid;
    assign pop     = (issue && head.is_wr && last) || (take && last);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat      <= 1'b0;
            wait_rd   <= 1'b0;
            lo_buf    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (issue) begin
                if (head.is_wr) beat <= !last;
                else            wait_rd <= 1'b1;
            end
            if (take) begin
                wait_rd <= 1'b0;
                if (last) begin
                    beat      <= 1'b0;
                    rsp_valid <= 1'b1;
                    if (head.wide)  rsp_data <= {n_rdata, lo_buf};
                    else if (lane)  rsp_data <= {n_rdata, {NW{1'b0}}};
                    else            rsp_data <= {{NW{1'b0}}, n_rdata};
                end else begin
                    lo_buf <= n_rdata;
                    beat   <= 1'b1;
                end
            end
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (n_valid && !(nce && n_ready)) |=> (n_valid && $stable(n_addr) && $stable(n_write)
                                            && $stable(n_wdata) && $stable(n_strb)))
        else $error("stalled beat changed"); // R9
    AST_RSP_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(nce && n_rvalid)) else $error("response without enabled read word"); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R11
    AST_READ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (issue && !n_write) |=> !n_valid) else $error("beat offered during outstanding read"); // R9
endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge
    import bridge_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           nce,
    input  logic           wr_valid,
    output logic           wr_ready,
    input  logic [31:0]    wr_addr,
    input  logic [63:0]    wr_data,
    input  logic [7:0]     wr_strb,
    input  logic           wr_wide,
    input  logic           rd_valid,
    output logic           rd_ready,
    input  logic [31:0]    rd_addr,
    input  logic           rd_wide,
    output logic           rsp_valid,
    output logic [63:0]    rsp_data,
    output logic           n_valid,
    input  logic           n_ready,
    output logic           n_write,
    output logic [31:0]    n_addr,
    output logic [31:0]    n_wdata,
    output logic [3:0]     n_strb,
    input  logic           n_rvalid,
    input  logic [31:0]    n_rdata
);
    localparam int CW = $clog2(DEPTH) + 1;

    cmd_t          wr_ent, rd_ent, head;
    logic [CW-1:0] fill;
    logic          push_w, push_r, pop;
    logic          room;

    // Two free slots are kept so both channels may push in one cycle.
    assign room     = (fill + CW'(2)) <= CW'(DEPTH);
    assign wr_ready = room;
    assign rd_ready = room;
    assign push_w   = wr_valid && room;
    assign push_r   = rd_valid && room;

    assign wr_ent = '{is_wr: 1'b1, wide: wr_wide, addr: wr_addr, data: wr_data, strb: wr_strb};
    assign rd_ent = '{is_wr: 1'b0, wide: rd_wide, addr: rd_addr, data: '0, strb: '0};

    bridge_cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_a (push_w),
        .ent_a  (wr_ent),
        .push_b (push_r),
        .ent_b  (rd_ent),
        .pop    (pop),
        .head   (head),
        .fill   (fill)
    );

    bridge_narrow_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .nce       (nce),
        .head      (head),
        .have      (fill != '0),
        .pop       (pop),
        .n_valid   (n_valid),
        .n_ready   (n_ready),
        .n_write   (n_write),
        .n_addr    (n_addr),
        .n_wdata   (n_wdata),
        .n_strb    (n_strb),
        .n_rvalid  (n_rvalid),
        .n_rdata   (n_rdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    AST_READY_RESET: assert property (@(posedge clk) $fell(rst) |-> (wr_ready && rd_ready && !n_valid))
        else $error("not idle after reset"); // R1
endmodule

// File: tb/wide_narrow_bridge_test.sv
module wide_narrow_bridge_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nce = 1'b0;
    logic        wr_valid = 1'b0, wr_wide = 1'b0, rd_valid = 1'b0, rd_wide = 1'b0;
    logic        wr_ready, rd_ready, rsp_valid;
    logic [31:0] wr_addr = '0, rd_addr = '0;
    logic [63:0] wr_data = '0, rsp_data;
    logic [7:0]  wr_strb = '0;
    logic        n_valid, n_write, n_ready = 1'b0, n_rvalid = 1'b0;
    logic [31:0] n_addr, n_wdata, n_rdata = '0;
    logic [3:0]  n_strb;

    always #4 clk = ~clk;

    wide_narrow_bridge #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .nce(nce),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .wr_wide(wr_wide),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_wide(rd_wide),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .n_valid(n_valid), .n_ready(n_ready), .n_write(n_write), .n_addr(n_addr),
        .n_wdata(n_wdata), .n_strb(n_strb), .n_rvalid(n_rvalid), .n_rdata(n_rdata)
    );

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [31:0] d;
        logic [3:0]  s;
        bit          last_rd;
    } beat_t;

    beat_t       exp_q[$];
    logic [63:0] exp_rsp[$];
    int          checks = 0, errors = 0;
    bit          done = 0;

    int          wr_pct = 0, rd_pct = 0, ready_pct = 0, div = 1, div_cnt = 0;
    bit          pend = 0, pend_last = 0, rsp_due = 0, hold = 0, wacc = 0, racc = 0;
    logic [31:0] pend_addr = '0;
    int          lat = 0, acc_w = 0;
    logic [31:0] p_addr, p_wdata;
    logic [3:0]  p_strb;
    logic        p_write;

    function automatic logic [31:0] rdfn(logic [31:0] a);
        return a ^ 32'h5A5A_0F0F ^ {a[15:0], a[31:16]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic void expect_cmd(bit wr, bit wide, logic [31:0] a, logic [63:0] d, logic [7:0] s);
        beat_t b;
        b.wr = wr;
        if (wide) begin
            b.addr = {a[31:3], 3'b000}; b.d = d[31:0]; b.s = s[3:0]; b.last_rd = 1'b0;
            exp_q.push_back(b);
            b.addr[2] = 1'b1; b.d = d[63:32]; b.s = s[7:4]; b.last_rd = !wr;
            exp_q.push_back(b);
            if (!wr) exp_rsp.push_back({rdfn(b.addr), rdfn({a[31:3], 3'b000})});
        end else begin
            b.addr = a; b.d = a[2] ? d[63:32] : d[31:0]; b.s = a[2] ? s[7:4] : s[3:0];
            b.last_rd = !wr;
            exp_q.push_back(b);
            if (!wr) exp_rsp.push_back(a[2] ? {rdfn(a), 32'h0} : {32'h0, rdfn(a)});
        end
    endfunction

    task automatic cycle();
        beat_t e;
        @(negedge clk);
        // drive inputs for the coming edge
        nce = (div_cnt == 0);
        div_cnt = (div_cnt + 1 >= div) ? 0 : div_cnt + 1;
        n_ready = ($urandom_range(99, 0) < ready_pct);
        if (pend) begin
            if (lat == 0) begin
                n_rvalid = 1'b1; n_rdata = rdfn(pend_addr);
            end else begin
                lat--; n_rvalid = 1'b0;
            end
        end else n_rvalid = 1'b0;
        if (wacc) wr_valid = 1'b0;
        if (racc) rd_valid = 1'b0;
        wacc = 0; racc = 0;
        if (!wr_valid && $urandom_range(99, 0) < wr_pct) begin
            wr_wide = $urandom_range(1, 0);
            wr_addr = $urandom() & 32'h0000_FFFC;
            if (wr_wide) wr_addr[2] = 1'b0;
            wr_data = {$urandom(), $urandom()};
            wr_strb = $urandom_range(255, 0);
            wr_valid = 1'b1;
        end
        if (!rd_valid && $urandom_range(99, 0) < rd_pct) begin
            rd_wide = $urandom_range(1, 0);
            rd_addr = $urandom() & 32'h0000_FFFC;
            if (rd_wide) rd_addr[2] = 1'b0;
            rd_valid = 1'b1;
        end
        #1;
        // response pulse timing and value (R4, R5, R11)
        if (rsp_due) begin
            logic [63:0] er;
            er = (exp_rsp.size() != 0) ? exp_rsp.pop_front() : 64'hDEAD;
            chk(rsp_valid === 1'b1, "R11", "response pulse missing", {63'h0, rsp_valid}, 64'h1);
            chk(rsp_data === er, "R4/R5", "read response data", rsp_data, er);
            rsp_due = 0;
        end else if (rsp_valid) begin
            chk(1'b0, "R11", "unexpected response pulse", rsp_data, 64'h0);
        end
        // stalled beat held (R9, R10)
        if (hold) begin
            chk(n_valid && n_addr === p_addr && n_write === p_write && n_wdata === p_wdata
                && n_strb === p_strb, "R9/R10", "held beat changed",
                {n_addr, n_wdata}, {p_addr, p_wdata});
        end
        // nothing offered while a read word is outstanding (R9)
        if (pend) chk(!n_valid, "R9", "beat offered during outstanding read", {63'h0, n_valid}, 64'h0);
        // read word taken (R10)
        if (pend && n_rvalid && nce) begin
            pend = 0;
            if (pend_last) rsp_due = 1;
        end
        // beat transfer against expected order (R2..R7, R10)
        if (n_valid && n_ready && nce) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected narrow beat", {n_addr, n_wdata}, 64'h0);
            end else begin
                e = exp_q.pop_front();
                if (e.wr)
                    chk(n_write && n_addr === e.addr && n_wdata === e.d && n_strb === e.s,
                        "R2/R3/R6/R7", "write beat", {n_addr, n_wdata}, {e.addr, e.d});
                else begin
                    chk(!n_write && n_addr === e.addr, "R4/R5/R6/R7", "read beat",
                        {31'h0, n_write, n_addr}, {32'h0, e.addr});
                    pend = 1; pend_addr = e.addr; pend_last = e.last_rd;
                    lat = $urandom_range(2, 0);
                end
            end
        end
        hold = n_valid && !(nce && n_ready);
        p_addr = n_addr; p_write = n_write; p_wdata = n_wdata; p_strb = n_strb;
        // wide-side acceptance, write before read (R7)
        if (wr_valid && wr_ready) begin
            expect_cmd(1'b1, wr_wide, wr_addr, wr_data, wr_strb);
            wacc = 1; acc_w++;
        end
        if (rd_valid && rd_ready) begin
            expect_cmd(1'b0, rd_wide, rd_addr, 64'h0, 8'h0);
            racc = 1;
        end
    endtask

    task automatic drain();
        bit busy;
        wr_pct = 0; rd_pct = 0; ready_pct = 80;
        busy = 1;
        for (int i = 0; i < 4000 && busy; i++) begin
            cycle();
            busy = exp_q.size() != 0 || exp_rsp.size() != 0 || pend || rsp_due
                   || wr_valid || rd_valid || wacc || racc;
        end
        chk(!busy, "R6", "queue not drained", {32'h0, 32'(exp_q.size())}, 64'h0);
    endtask

    initial begin
        void'($urandom(32'h0B1D_6E5));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(n_valid === 1'b0, "R1", "n_valid after reset", {63'h0, n_valid}, 64'h0);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
        chk(wr_ready === 1'b1, "R1", "wr_ready after reset", {63'h0, wr_ready}, 64'h1);
        chk(rd_ready === 1'b1, "R1", "rd_ready after reset", {63'h0, rd_ready}, 64'h1);

        // fill with the narrow side stalled (R8)
        wr_pct = 100; rd_pct = 0; ready_pct = 0; div = 1; acc_w = 0;
        repeat (20) cycle();
        chk(acc_w == DEPTH - 1, "R8", "writes accepted while stalled", 64'(acc_w), 64'(DEPTH - 1));
        chk(!wr_ready && !rd_ready, "R8", "ready with one slot free",
            {62'h0, wr_ready, rd_ready}, 64'h0);
        drain();

        // both channels every cycle: same-cycle tie-break (R7)
        wr_pct = 100; rd_pct = 100; ready_pct = 100; div = 1;
        repeat (8) cycle();
        drain();

        // random traffic at narrow clock ratios 1, 2 and 3 (R10)
        for (int r = 1; r <= 3; r++) begin
            div = r; div_cnt = 0;
            wr_pct = 40; rd_pct = 40; ready_pct = 70;
            repeat (3000) cycle();
            drain();
        end
        chk(exp_q.size() == 0 && exp_rsp.size() == 0, "R6", "leftover expectations",
            64'(exp_q.size()), 64'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R6 watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule